// File: doc/BRIEF.md
# Single-cycle RISC subset core

This block runs a small subset of a 32-bit load/store RISC instruction set, completing one instruction per clock. It holds a 32-entry register file, a program counter, an ALU, a hi/lo pair for multiply results, and two internal word memories: one for instructions and one for data. While `rst_n` is low, a simple write port fills either memory. When reset is released, execution starts at address 0.

Each cycle the core shows, on a write-back observation port, the register result that the current instruction will commit at the next rising edge. A word load or store whose effective address is not a multiple of 4 does not perform its access. Instead the core raises `trap`, latches the faulting PC and stops until the next reset.

Branches add the sign-extended 16-bit offset, taken as a byte offset, to the PC of the branch itself. Jumps load the 26-bit target shifted left by two. There are no delay slots.

Top module: `tr_core`

## Requirements
- R1: While `rst_n` is low, `pc` reads 0, `trap` reads 0, `wb_valid` reads 0 and all registers clear. A preload write (`ld_en`=1, `ld_dmem` selects data memory when 1, word index `ld_addr`) takes effect only while `rst_n` is low and is ignored otherwise. Memory contents survive reset.
- R2: Each instruction is fetched from instruction word `pc[7:2]`. Every instruction that does not transfer control advances `pc` by 4 at the next edge.
- R3: Register-form instructions have opcode bits[31:26]=0, with rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. They write rd with add (0x20), sub (0x22), and (0x24), or (0x25).
- R4: Immediate-form instructions use opcode, rs, rt as the destination, and imm[15:0]. addi (0x08) sign-extends the immediate. andi (0x0C) and ori (0x0D) zero-extend it.
- R5: Shifts take rt by shamt: sll (funct 0x00), srl (0x02, logical) and sra (0x03, arithmetic).
- R6: slt (funct 0x2A) and slti (op 0x0A) write 1 when rs is less than the second operand as signed values, otherwise 0. sltu (0x2B) and sltiu (0x0B) make the same comparison unsigned. The immediate is sign-extended in both cases.
- R7: lw (op 0x23) writes data word (rs+sext(imm))[7:2] into rt. sw (op 0x2B) writes rt to that word.
- R8: beq (0x04), bne (0x05), blez (0x06) and bgtz (0x07) set `pc` to pc+sext(imm) when their condition holds, otherwise pc+4. Op 0x01 with rt=0 is bltz and with rt=1 is bgez. All zero comparisons are signed.
- R9: j (op 0x02) sets `pc` to {imm26,2'b00}. jal (0x03) does the same and writes pc+4 into register 31. jr (funct 0x08) sets `pc` to rs.
- R10: mult (funct 0x18) places the signed 64-bit product of rs and rt into hi:lo. mfhi (0x10) and mflo (0x12) copy hi or lo to rd. mthi (0x11) and mtlo (0x13) copy rs to hi or lo.
- R11: Register 0 reads as zero. A write aimed at it is discarded and shows `wb_valid`=0.
- R12: A lw or sw whose effective address has nonzero bits[1:0] performs no memory or register write. From the next edge until reset, `trap`=1, `trap_pc` holds the faulting PC, and `pc` stops changing.
- R13: `wb_valid`, `wb_reg` and `wb_value` show, during the cycle an instruction executes, the register write it commits at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; preload window |
| ld_en | input | 1 | Preload write strobe |
| ld_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| ld_addr | input | MEM_AW | Preload word index |
| ld_data | input | 32 | Preload word |
| pc | output | 32 | Current program counter |
| wb_valid | output | 1 | Current instruction writes a register |
| wb_reg | output | 5 | Destination register index |
| wb_value | output | 32 | Value being written |
| trap | output | 1 | Misaligned access seen; core halted |
| trap_pc | output | 32 | PC of the faulting instruction |

## Verification
The hardest condition to reach from the ports is a misaligned store. It leaves no register result, and its only lasting effect would be on data memory, which cannot be read back while the core is halted. The stimulus first preloads a known data word and then traps on a misaligned store to it. Next it attempts a preload of that word while out of reset. Finally it resets and runs a single load of the same word. The loaded value proves that neither the store nor the late preload reached memory.

// File: rtl/tr_pkg.sv
// Shared constants and types for the RISC subset core.
// Assumes a 32-bit datapath and 32 architectural registers.
package tr_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RIDX_W = $clog2(NREG);

    // primary opcodes
    localparam logic [5:0] OP_REG   = 6'h00;
    localparam logic [5:0] OP_ZCMP  = 6'h01;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_JAL   = 6'h03;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_BNE   = 6'h05;
    localparam logic [5:0] OP_BLEZ  = 6'h06;
    localparam logic [5:0] OP_BGTZ  = 6'h07;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_SLTI  = 6'h0A;
    localparam logic [5:0] OP_SLTIU = 6'h0B;
    localparam logic [5:0] OP_ANDI  = 6'h0C;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    // function codes of the register form
    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_JR   = 6'h08;
    localparam logic [5:0] FN_MFHI = 6'h10;
    localparam logic [5:0] FN_MTHI = 6'h11;
    localparam logic [5:0] FN_MFLO = 6'h12;
    localparam logic [5:0] FN_MTLO = 6'h13;
    localparam logic [5:0] FN_MULT = 6'h18;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_SLT  = 6'h2A;
    localparam logic [5:0] FN_SLTU = 6'h2B;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR,
        ALU_SLL, ALU_SRL, ALU_SRA, ALU_SLT, ALU_SLTU
    } alu_op_e;
endpackage

// File: rtl/tr_regfile.sv
// Two-read, one-write register file. Index 0 reads zero and ignores writes.
// Assumes writes happen at the rising edge; reads are combinational.
module tr_regfile
    import tr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] ra_idx,
    output logic [XLEN-1:0]   ra_val,
    input  logic [RIDX_W-1:0] rb_idx,
    output logic [XLEN-1:0]   rb_val,
    input  logic              we,
    input  logic [RIDX_W-1:0] w_idx,
    input  logic [XLEN-1:0]   w_val
);
    logic [XLEN-1:0] regs [NREG];

    // clear on reset, otherwise take one write per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && w_idx != '0) begin
            regs[w_idx] <= w_val;
        end
    end

    // read ports with the hard-wired zero register
    always_comb begin
        ra_val = (ra_idx == '0) ? '0 : regs[ra_idx];
        rb_val = (rb_idx == '0) ? '0 : regs[rb_idx];
    end
endmodule

// File: rtl/tr_alu.sv
// Combinational ALU: add, subtract, logic, shifts and set-less-than.
// Assumes shift operands arrive on a with the amount on shamt.
module tr_alu
    import tr_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [4:0]      shamt,
    output logic [XLEN-1:0] y
);
    // select the operation result
    always_comb begin
        unique case (op)
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_SLL:  y = a << shamt;
            ALU_SRL:  y = a >> shamt;
            ALU_SRA:  y = XLEN'($signed(a) >>> shamt);
            ALU_SLT:  y = XLEN'($signed(a) < $signed(b));
            ALU_SLTU: y = XLEN'(a < b);
            default:  y = a + b;
        endcase
    end
endmodule

// File: rtl/tr_core.sv
// Single-cycle core for a RISC subset with internal instruction/data memories.
// Assumes memories are preloaded only while rst_n is low; a misaligned word
// access halts the core until the next reset.
module tr_core
    import tr_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              ld_dmem,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    output logic [XLEN-1:0]   pc,
    output logic              wb_valid,
    output logic [RIDX_W-1:0] wb_reg,
    output logic [XLEN-1:0]   wb_value,
    output logic              trap,
    output logic [XLEN-1:0]   trap_pc
);
    localparam int MEM_WORDS = 1 << MEM_AW;

    logic [XLEN-1:0] imem [MEM_WORDS];
    logic [XLEN-1:0] dmem [MEM_WORDS];
    logic [XLEN-1:0] pc_q, hi_q, lo_q, trap_pc_q;
    logic            halted_q;

    logic [XLEN-1:0]   ir, rs_val, rt_val, imm_s, imm_z, ea, ld_val;
    logic [5:0]        opc, fn;
    logic [RIDX_W-1:0] rs, rt, rd;
    logic [4:0]        sh;
    logic [2*XLEN-1:0] prod;

    alu_op_e           alu_op;
    logic [XLEN-1:0]   alu_a, alu_b, alu_y, wr_val, next_pc, pc_inc;
    logic [RIDX_W-1:0] wr_idx;
    logic              wr_en, is_ld, is_st, mul_we, hi_we, lo_we, ctl_xfer;
    logic              misalign, run, commit_wr;
    logic [MEM_AW-1:0] ea_idx;
    logic              unused_ea;

    assign ir     = imem[pc_q[MEM_AW+1:2]];
    assign opc    = ir[31:26];
    assign rs     = ir[25:21];
    assign rt     = ir[20:16];
    assign rd     = ir[15:11];
    assign sh     = ir[10:6];
    assign fn     = ir[5:0];
    assign imm_s  = {{(XLEN-16){ir[15]}}, ir[15:0]};
    assign imm_z  = {{(XLEN-16){1'b0}}, ir[15:0]};
    assign pc_inc = pc_q + XLEN'(4);
    assign ea     = rs_val + imm_s;
    assign ea_idx = ea[MEM_AW+1:2];
    assign ld_val = dmem[ea_idx];
    assign prod   = $signed({{XLEN{rs_val[XLEN-1]}}, rs_val})
                  * $signed({{XLEN{rt_val[XLEN-1]}}, rt_val});
    assign unused_ea = ^{ea[XLEN-1:MEM_AW+2]};

    tr_regfile u_rf (
        .clk(clk), .rst_n(rst_n),
        .ra_idx(rs), .ra_val(rs_val),
        .rb_idx(rt), .rb_val(rt_val),
        .we(commit_wr), .w_idx(wr_idx), .w_val(wr_val)
    );

    tr_alu u_alu (.op(alu_op), .a(alu_a), .b(alu_b), .shamt(sh), .y(alu_y));

    // decode the current instruction into datapath controls and next PC
    always_comb begin
        alu_op = ALU_ADD;  alu_a = rs_val;  alu_b = rt_val;
        wr_en = 1'b0;      wr_idx = rd;     wr_val = alu_y;
        is_ld = 1'b0;      is_st = 1'b0;
        mul_we = 1'b0;     hi_we = 1'b0;    lo_we = 1'b0;
        next_pc = pc_inc;  ctl_xfer = 1'b0;
        case (opc)
            OP_REG: begin
                case (fn)
                    FN_ADD:  begin wr_en = 1'b1; alu_op = ALU_ADD;  end
                    FN_SUB:  begin wr_en = 1'b1; alu_op = ALU_SUB;  end
                    FN_AND:  begin wr_en = 1'b1; alu_op = ALU_AND;  end
                    FN_OR:   begin wr_en = 1'b1; alu_op = ALU_OR;   end
                    FN_SLT:  begin wr_en = 1'b1; alu_op = ALU_SLT;  end
                    FN_SLTU: begin wr_en = 1'b1; alu_op = ALU_SLTU; end
                    FN_SLL:  begin wr_en = 1'b1; alu_op = ALU_SLL; alu_a = rt_val; end
                    FN_SRL:  begin wr_en = 1'b1; alu_op = ALU_SRL; alu_a = rt_val; end
                    FN_SRA:  begin wr_en = 1'b1; alu_op = ALU_SRA; alu_a = rt_val; end
                    FN_JR:   begin next_pc = rs_val; ctl_xfer = 1'b1; end
                    FN_MULT: mul_we = 1'b1;
                    FN_MFHI: begin wr_en = 1'b1; wr_val = hi_q; end
                    FN_MFLO: begin wr_en = 1'b1; wr_val = lo_q; end
                    FN_MTHI: hi_we = 1'b1;
                    FN_MTLO: lo_we = 1'b1;
                    default: ;
                endcase
            end
            OP_ADDI:  begin wr_en = 1'b1; wr_idx = rt; alu_b = imm_s; end
            OP_SLTI:  begin wr_en = 1'b1; wr_idx = rt; alu_b = imm_s; alu_op = ALU_SLT;  end
            OP_SLTIU: begin wr_en = 1'b1; wr_idx = rt; alu_b = imm_s; alu_op = ALU_SLTU; end
            OP_ANDI:  begin wr_en = 1'b1; wr_idx = rt; alu_b = imm_z; alu_op = ALU_AND;  end
            OP_ORI:   begin wr_en = 1'b1; wr_idx = rt; alu_b = imm_z; alu_op = ALU_OR;   end
            OP_LW:    begin wr_en = 1'b1; wr_idx = rt; wr_val = ld_val; is_ld = 1'b1; end
            OP_SW:    is_st = 1'b1;
            OP_BEQ:   ctl_xfer = (rs_val == rt_val);
            OP_BNE:   ctl_xfer = (rs_val != rt_val);
            OP_BLEZ:  ctl_xfer = ($signed(rs_val) <= 0);
            OP_BGTZ:  ctl_xfer = ($signed(rs_val) > 0);
            OP_ZCMP:  begin
                if (rt == 5'd0)      ctl_xfer = rs_val[XLEN-1];
                else if (rt == 5'd1) ctl_xfer = !rs_val[XLEN-1];
            end
            OP_J:     begin ctl_xfer = 1'b1; next_pc = {4'b0, ir[25:0], 2'b00}; end
            OP_JAL:   begin
                ctl_xfer = 1'b1; next_pc = {4'b0, ir[25:0], 2'b00};
                wr_en = 1'b1; wr_idx = RIDX_W'(NREG-1); wr_val = pc_inc;
            end
            default: ;
        endcase
        // conditional branches reuse ctl_xfer as their taken flag
        if (ctl_xfer && (opc == OP_BEQ || opc == OP_BNE || opc == OP_BLEZ ||
                         opc == OP_BGTZ || opc == OP_ZCMP))
            next_pc = pc_q + imm_s;
    end

    assign misalign  = (is_ld || is_st) && (ea[1:0] != 2'b00);
    assign run       = rst_n && !halted_q;
    assign commit_wr = run && wr_en && !misalign;

    // program counter, trap capture and hi/lo state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0; hi_q <= '0; lo_q <= '0; trap_pc_q <= '0; halted_q <= 1'b0;
        end else if (!halted_q) begin
            if (misalign) begin
                halted_q  <= 1'b1;
                trap_pc_q <= pc_q;
            end else begin
                pc_q <= next_pc;
                if (mul_we) {hi_q, lo_q} <= prod;
                if (hi_we)  hi_q <= rs_val;
                if (lo_we)  lo_q <= rs_val;
            end
        end
    end

    // instruction memory: preload only during reset
    always_ff @(posedge clk) begin
        if (!rst_n && ld_en && !ld_dmem) imem[ld_addr] <= ld_data;
    end

    // data memory: preload during reset, aligned stores while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (ld_en && ld_dmem) dmem[ld_addr] <= ld_data;
        end else if (run && is_st && !misalign) begin
            dmem[ea_idx] <= rt_val;
        end
    end

    assign pc       = pc_q;
    assign trap     = halted_q;
    assign trap_pc  = trap_pc_q;
    assign wb_valid = commit_wr && (wr_idx != '0);
    assign wb_reg   = wr_idx;
    assign wb_value = wr_val;
endmodule

// File: rtl/tr_core_chk.sv
// Temporal checks on control flow and trap behaviour of tr_core.
// Assumes it is bound to the top module and sees its internal decode flags.
module tr_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic        trap,
    input logic [31:0] trap_pc,
    input logic        wb_valid,
    input logic        ctl_xfer,
    input logic        misalign
);
    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap && !ctl_xfer && !misalign) |=> (pc == $past(pc) + 32'd4)); // R2

    AST_TRAP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap && misalign) |=> (trap && trap_pc == $past(pc))); // R12

    AST_TRAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> (trap && $stable(pc) && $stable(trap_pc))); // R12

    AST_HALT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !wb_valid); // R12

    AST_RESET_CLEAN: assert property (@(posedge clk)
        $rose(rst_n) |-> (pc == 32'd0 && !trap)); // R1
endmodule

bind tr_core tr_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pc(pc), .trap(trap), .trap_pc(trap_pc),
    .wb_valid(wb_valid), .ctl_xfer(ctl_xfer), .misalign(misalign)
);

// File: tb/tr_core_tb.sv
`timescale 1ns/100ps
module tr_core_tb;
    localparam int MEM_AW = 6;
    localparam int N = 35;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ld_en = 1'b0;
    logic              ld_dmem = 1'b0;
    logic [MEM_AW-1:0] ld_addr = '0;
    logic [31:0]       ld_data = '0;
    logic [31:0]       pc, wb_value, trap_pc;
    logic              wb_valid, trap;
    logic [4:0]        wb_reg;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    tr_core #(.MEM_AW(MEM_AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_dmem(ld_dmem),
        .ld_addr(ld_addr), .ld_data(ld_data), .pc(pc), .wb_valid(wb_valid),
        .wb_reg(wb_reg), .wb_value(wb_value), .trap(trap), .trap_pc(trap_pc)
    );

    always #2 clk = ~clk;

    // expected trace: pc, write-back flag, destination, value
    localparam logic [31:0] E_PC [N] = '{
        32'h00, 32'h04, 32'h08, 32'h0C, 32'h10, 32'h14, 32'h18, 32'h1C,
        32'h20, 32'h24, 32'h28, 32'h2C, 32'h30, 32'h34, 32'h38, 32'h3C,
        32'h40, 32'h44, 32'h48, 32'h4C, 32'h50, 32'h58, 32'h5C, 32'h64,
        32'h68, 32'h70, 32'h74, 32'h78, 32'h7C, 32'h88, 32'h80, 32'h90,
        32'h8C, 32'h94, 32'h98};
    localparam logic E_V [N] = '{
        1,1,1,1,1,1,1,1, 1,1,1,0,1,0,1,0, 1,1,0,1,0,0,0,0, 0,0,1,1,1,0,0,0, 0,1,0};
    localparam logic [4:0] E_R [N] = '{
        5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8,
        5'd9, 5'd10, 5'd11, 5'd0, 5'd12, 5'd0, 5'd13, 5'd0,
        5'd14, 5'd15, 5'd0, 5'd16, 5'd0, 5'd0, 5'd0, 5'd0,
        5'd0, 5'd0, 5'd17, 5'd18, 5'd31, 5'd0, 5'd0, 5'd0,
        5'd0, 5'd19, 5'd0};
    localparam logic [31:0] E_D [N] = '{
        32'd5, 32'hFFFFFFFD, 32'd2, 32'hFFFFFFF8, 32'd1, 32'd0, 32'h0000FFFF, 32'h0000F0F0,
        32'hFFFFFFFC, 32'hF, 32'h50, 32'd0, 32'd5, 32'd0, 32'hFFFFFFF8, 32'd0,
        32'hFFFFFFFF, 32'hFFFFFFF1, 32'd0, 32'd5, 32'd0, 32'd0, 32'd0, 32'd0,
        32'd0, 32'd0, 32'd1, 32'd1, 32'h80, 32'd0, 32'd0, 32'd0,
        32'd0, 32'd82, 32'd0};
    // requirement exercised by each row
    localparam string E_TAG [N] = '{
        "R4","R4","R3","R3","R6","R6","R4","R4",
        "R5","R5","R5","R11","R11","R7","R7","R10",
        "R10","R10","R10","R10","R8","R8","R8","R8",
        "R8","R8","R6","R6","R9","R9","R9","R8",
        "R9","R13","R12"};

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(int op, int tgt);
        return {6'(op), 26'(tgt)};
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(bit dm, int byte_addr, logic [31:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_dmem = dm; ld_addr = MEM_AW'(byte_addr >> 2); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    initial begin
        // ---- run 1: main program
        put(0, 'h00, enc_i('h08, 0, 1, 5));
        put(0, 'h04, enc_i('h08, 0, 2, -3));
        put(0, 'h08, enc_r(1, 2, 3, 0, 'h20));
        put(0, 'h0C, enc_r(2, 1, 4, 0, 'h22));
        put(0, 'h10, enc_r(2, 1, 5, 0, 'h2A));
        put(0, 'h14, enc_r(2, 1, 6, 0, 'h2B));
        put(0, 'h18, enc_i('h0D, 0, 7, 'hFFFF));
        put(0, 'h1C, enc_i('h0C, 2, 8, 'hF0F0));
        put(0, 'h20, enc_r(0, 4, 9, 1, 'h03));
        put(0, 'h24, enc_r(0, 4, 10, 28, 'h02));
        put(0, 'h28, enc_r(0, 1, 11, 4, 'h00));
        put(0, 'h2C, enc_i('h08, 0, 0, 7));
        put(0, 'h30, enc_r(0, 1, 12, 0, 'h20));
        put(0, 'h34, enc_i('h2B, 0, 4, 8));
        put(0, 'h38, enc_i('h23, 0, 13, 8));
        put(0, 'h3C, enc_r(2, 1, 0, 0, 'h18));
        put(0, 'h40, enc_r(0, 0, 14, 0, 'h10));
        put(0, 'h44, enc_r(0, 0, 15, 0, 'h12));
        put(0, 'h48, enc_r(1, 0, 0, 0, 'h13));
        put(0, 'h4C, enc_r(0, 0, 16, 0, 'h12));
        put(0, 'h50, enc_i('h04, 1, 12, 8));
        put(0, 'h54, enc_i('h08, 0, 20, 99));
        put(0, 'h58, enc_i('h05, 1, 12, 8));
        put(0, 'h5C, enc_i('h01, 2, 0, 8));
        put(0, 'h60, enc_i('h08, 0, 20, 99));
        put(0, 'h64, enc_i('h01, 2, 1, 8));
        put(0, 'h68, enc_i('h06, 0, 0, 8));
        put(0, 'h6C, enc_i('h08, 0, 20, 99));
        put(0, 'h70, enc_i('h07, 0, 0, 8));
        put(0, 'h74, enc_i('h0A, 2, 17, -2));
        put(0, 'h78, enc_i('h0B, 1, 18, -1));
        put(0, 'h7C, enc_j('h03, 'h22));
        put(0, 'h80, enc_j('h02, 'h24));
        put(0, 'h84, enc_i('h08, 0, 20, 99));
        put(0, 'h88, enc_r(31, 0, 0, 0, 'h08));
        put(0, 'h8C, enc_j('h02, 'h25));
        put(0, 'h90, enc_i('h04, 0, 0, -4));
        put(0, 'h94, enc_i('h08, 1, 19, 77));
        put(0, 'h98, enc_i('h23, 0, 20, 2));
        #0.5;
        check(pc == 32'd0, "R1 reset pc", pc, 32'd0);
        check(!trap && !wb_valid, "R1 reset flags", {30'd0, trap, wb_valid}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < N; i++) begin
            #0.5;
            check(pc == E_PC[i], {E_TAG[i], " pc"}, pc, E_PC[i]);
            check(wb_valid == E_V[i], {E_TAG[i], " wb_valid"}, 32'(wb_valid), 32'(E_V[i]));
            if (E_V[i])
                check(wb_reg == E_R[i] && wb_value == E_D[i], {E_TAG[i], " wb data"},
                      {wb_reg, wb_value[26:0]}, {E_R[i], E_D[i][26:0]});
            @(negedge clk);
        end
        #0.5;
        check(trap && trap_pc == 32'h98, "R12 trap on misaligned lw", trap_pc, 32'h98);
        repeat (3) @(negedge clk);
        #0.5;
        check(trap && pc == 32'h98 && trap_pc == 32'h98, "R12 halt holds", pc, 32'h98);

        // ---- run 2: misaligned store, then preload attempt out of reset
        rst_n = 1'b0;
        put(1, 'h04, 32'h12345678);
        put(0, 'h00, enc_i('h08, 0, 1, 9));
        put(0, 'h04, enc_i('h2B, 0, 1, 5));
        #0.5;
        check(!trap && pc == 32'd0, "R1 reset clears trap", {31'd0, trap}, 32'd0);
        rst_n = 1'b1;
        #0.5;
        check(wb_valid && wb_reg == 5'd1 && wb_value == 32'd9, "R4 run2 addi", wb_value, 32'd9);
        @(negedge clk); #0.5;
        check(pc == 32'h4 && !wb_valid, "R12 misaligned sw no wb", pc, 32'h4);
        @(negedge clk); #0.5;
        check(trap && trap_pc == 32'h4, "R12 trap on misaligned sw", trap_pc, 32'h4);
        put(1, 'h04, 32'hDEADBEEF);

        // ---- run 3: read back the protected data word
        rst_n = 1'b0;
        put(0, 'h00, enc_i('h23, 0, 2, 4));
        rst_n = 1'b1;
        #0.5;
        check(wb_valid && wb_reg == 5'd2 && wb_value == 32'h12345678,
              "R1 R12 data word untouched", wb_value, 32'h12345678);
        @(negedge clk); #0.5;
        check(pc == 32'h4, "R2 advance after lw", pc, 32'h4);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end
endmodule